// File: doc/BRIEF.md
# PHY Test Register Access Port

This block is the PHY-side end of a slow, software-toggled test interface that reaches a bank of byte-wide configuration registers. A controller drives four signals as plain levels: a clear line, a test clock, an enable line and one byte-wide data bus. The same byte bus carries both addresses and data. The level of the enable line at a rising test-clock edge decides which one the byte is. When enable is high, the byte becomes the current address. When enable is low, the byte is stored into the register at the current address. The read-back byte always shows the register at the current address. A read is therefore just an address phase followed by a short wait.

The test signals come from a slow source that is unrelated to the block's clock. The block samples them through a short synchronizer chain and finds test-clock rising edges by comparing the synchronized level with its previous value. The register bank is written in a form that maps onto block RAM. Clearing the bank takes a single cycle because each entry has a separate valid bit. An entry whose valid bit is cleared reads as zero.

Top module: `phy_test_port`

## Requirements
- R1: While `rst` is high and after it falls, the current address is 0 and every register reads as 0x00 on `tst_dout`.
- R2: A rising edge of `tst_clk` while `tst_en` is 1 makes `tst_din` the current address. No register changes.
- R3: A rising edge of `tst_clk` while `tst_en` is 0 stores `tst_din` into the register at the current address. The other registers keep their values.
- R4: `tst_dout` shows the register at the current address. It is updated on the fifth rising edge of `clk` after the input change that caused the update. At four edges it still shows the old value.
- R5: `tst_clr` at 1 sets the current address to 0 and makes every register read as 0x00. It also overrides a `tst_clk` rising edge that is sampled together with it.
- R6: A falling edge of `tst_clk`, or any change of `tst_en` or `tst_din` without a rising edge of `tst_clk`, changes neither the address nor any register, so `tst_dout` holds its value.
- R7: The current address does not advance. Repeated data phases after one address phase all write the same register, and the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the test signals |
| rst | input | 1 | Synchronous active-high reset |
| tst_clr | input | 1 | Test clear, active high |
| tst_clk | input | 1 | Test clock, software toggled; its rising edge is sampled |
| tst_en | input | 1 | 1 = address phase, 0 = data phase at a test-clock rising edge |
| tst_din | input | DW | Address or data byte |
| tst_dout | output | DW | Register at the current address, registered |

## Verification
Every result comes from a path of five `clk` registers from the pins to `tst_dout`. The path is two synchronizer stages, the edge-qualified address or register update, the RAM read stage and the output register. So a test-pin change first becomes visible after the fifth `clk` rising edge. The bench changes inputs only on falling edges of `clk` and waits eight cycles before it samples, which keeps every check clear of that window. The latency check counts edges exactly: it expects the old value after four edges and the new value after five. The bound checker uses the same three-cycle spacing between an internal strobe and the output.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

  // Operation decoded from the synchronized test pins in one clk cycle.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ADDR  = 2'd1,
    OP_DATA  = 2'd2,
    OP_CLEAR = 2'd3
  } tap_op_e;

endpackage

// File: rtl/ptp_sync.sv
module ptp_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ptp_decode.sv
module ptp_decode
  import ptp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr_s,
  input  logic    tck_s,
  input  logic    en_s,
  output tap_op_e op
);

  logic tck_d;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) tck_d <= 1'b0;
    else     tck_d <= tck_s;
  end

  assign rise = tck_s & ~tck_d;

  always_comb begin
    if (clr_s)     op = OP_CLEAR;
    else if (rise) op = en_s ? OP_ADDR : OP_DATA;
    else           op = OP_NONE;
  end

endmodule

// File: rtl/ptp_regfile.sv
module ptp_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // Data array: no reset, single write port, registered read (RAM-friendly).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[raddr];
  end

  // Per-entry valid bits give a one-cycle clear of the whole bank.
  always_ff @(posedge clk) begin
    if (rst || clr)  vld_q <= '0;
    else if (we)     vld_q[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= vld_q[raddr];
  end

endmodule

// File: rtl/phy_test_port.sv
module phy_test_port
  import ptp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tst_clr,
  input  logic          tst_clk,
  input  logic          tst_en,
  input  logic [DW-1:0] tst_din,
  output logic [DW-1:0] tst_dout
);

  localparam int AW  = DW;      // address shares the data bus
  localparam int BW  = DW + 3;  // bundle: clr, clk, en, din

  logic [BW-1:0] pins_s;
  logic          clr_s;
  logic          tck_s;
  logic          en_s;
  logic [DW-1:0] din_s;
  tap_op_e       op;
  logic          addr_stb;
  logic          dat_stb;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_data;
  logic          rd_vld;
  logic [DW-1:0] dout_q;

  ptp_sync #(.W(BW), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({tst_clr, tst_clk, tst_en, tst_din}),
    .q   (pins_s)
  );

  assign {clr_s, tck_s, en_s, din_s} = pins_s;

  ptp_decode decode_i (
    .clk   (clk),
    .rst   (rst),
    .clr_s (clr_s),
    .tck_s (tck_s),
    .en_s  (en_s),
    .op    (op)
  );

  assign addr_stb = (op == OP_ADDR);
  assign dat_stb  = (op == OP_DATA);

  always_ff @(posedge clk) begin
    if (rst || op == OP_CLEAR) addr_q <= '0;
    else if (addr_stb)         addr_q <= din_s[AW-1:0];
  end

  ptp_regfile #(.AW(AW), .DW(DW)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (op == OP_CLEAR),
    .we      (dat_stb),
    .waddr   (addr_q),
    .wdata   (din_s),
    .raddr   (addr_q),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= rd_vld ? rd_data : '0;
  end

  assign tst_dout = dout_q;

endmodule

// File: rtl/phy_test_port_chk.sv
module phy_test_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_s,
  input logic          addr_stb,
  input logic          dat_stb,
  input logic [DW-1:0] din_s,
  input logic [DW-1:0] addr_q,
  input logic [DW-1:0] dout
);

  // R1
  reset_addr_chk: assert property (@(posedge clk) rst |=> (addr_q == '0));

  // R1
  reset_dout_chk: assert property (@(posedge clk) rst |=> (dout == '0));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_stb |=> (addr_q == $past(din_s)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_stb && !clr_s) |=> $stable(addr_q));

  // R5
  clear_addr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> (addr_q == '0));

  // R5
  clear_dout_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_s, 3) && !$past(rst, 1) && !$past(rst, 2)) |-> (dout == '0));

  // R4
  write_dout_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dat_stb, 3) && !$past(rst, 1) && !$past(rst, 2))
      |-> (dout == $past(din_s, 3)));

  // R6
  idle_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(addr_stb, 3) && !$past(dat_stb, 3) && !$past(clr_s, 3) &&
     !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> $stable(dout));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dat_stb && (addr_stb || clr_s)));

endmodule

bind phy_test_port phy_test_port_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clr_s    (clr_s),
  .addr_stb (addr_stb),
  .dat_stb  (dat_stb),
  .din_s    (din_s),
  .addr_q   (addr_q),
  .dout     (tst_dout)
);

// File: tb/phy_test_port_tb_top.sv
`timescale 1ns/1ps
module phy_test_port_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 1 << DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tst_clr = 1'b0;
  logic          tst_clk = 1'b0;
  logic          tst_en = 1'b0;
  logic [DW-1:0] tst_din = '0;
  logic [DW-1:0] tst_dout;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  phy_test_port #(.DW(DW), .SYNC_STAGES(2)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .tst_clr  (tst_clr),
    .tst_clk  (tst_clk),
    .tst_en   (tst_en),
    .tst_din  (tst_din),
    .tst_dout (tst_dout)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 29 + 113) % DEPTH);
  endfunction

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic check(logic [DW-1:0] got, logic [DW-1:0] exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic pulse();
    tst_clk = 1'b1; settle();
    tst_clk = 1'b0; settle();
  endtask

  task automatic set_addr(int a);
    tst_en = 1'b1; tst_din = DW'(a); settle();
    pulse();
    tst_en = 1'b0;
  endtask

  task automatic write_reg(int a, logic [DW-1:0] v);
    set_addr(a);
    tst_din = v; settle();
    pulse();
    model[a] = v;
  endtask

  task automatic read_chk(int a, string req);
    set_addr(a);
    settle();
    check(tst_dout, model[a], req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1: reset state
    check(tst_dout, 8'h00, "R1 dout after reset");
    read_chk(0,   "R1 reg0 zero");
    read_chk(1,   "R1 reg1 zero");
    read_chk(128, "R1 reg128 zero");
    read_chk(255, "R1 reg255 zero");

    // R3: write every register, then R4 read each back
    for (int a = 0; a < DEPTH; a++) write_reg(a, pat(a));
    for (int a = 0; a < DEPTH; a++) read_chk(a, "R3 sweep readback");

    // R2: address phase alone leaves registers alone
    set_addr(20); settle();
    check(tst_dout, model[20], "R2 addr phase shows reg20");
    set_addr(21); settle();
    read_chk(20, "R2 reg20 unchanged after address phases");

    // R7: two data phases after one address phase
    set_addr(50);
    tst_din = 8'h11; settle(); pulse();
    tst_din = 8'h22; settle(); pulse();
    model[50] = 8'h22;
    check(tst_dout, 8'h22, "R7 last data phase wins");
    read_chk(51, "R7 neighbour untouched");
    read_chk(50, "R7 reg50 value");

    // R6: no rising edge -> nothing changes
    tst_en = 1'b1; tst_din = 8'd60; settle();
    tst_clk = 1'b1; settle();
    tst_en = 1'b0; tst_din = 8'hEE; settle();
    tst_en = 1'b1; tst_din = 8'd61; settle();
    tst_en = 1'b0; tst_din = 8'hEE; settle();
    tst_clk = 1'b0; settle();
    check(tst_dout, model[60], "R6 falling edge and level changes ignored");
    read_chk(60, "R6 reg60 unchanged");

    // R4: exact output latency
    set_addr(70);
    tst_din = ~model[70]; settle();
    @(negedge clk) tst_clk = 1'b1;
    repeat (4) @(negedge clk);
    check(tst_dout, model[70], "R4 old value after four edges");
    @(negedge clk);
    check(tst_dout, ~model[70], "R4 new value after five edges");
    model[70] = ~model[70];
    settle(); tst_clk = 1'b0; settle();

    // R5: clear resets address and registers
    tst_clr = 1'b1; settle(); tst_clr = 1'b0; settle();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    check(tst_dout, 8'h00, "R5 dout zero after clear");
    tst_en = 1'b0; tst_din = 8'h3C; settle(); pulse();
    model[0] = 8'h3C;
    check(tst_dout, 8'h3C, "R5 address reset to 0");
    read_chk(1,   "R5 reg1 cleared");
    read_chk(100, "R5 reg100 cleared");
    read_chk(255, "R5 reg255 cleared");

    // R5: clear overrides a coincident test-clock edge
    write_reg(5, 8'h5A);
    tst_en = 1'b0; tst_din = 8'h77; settle();
    @(negedge clk) begin tst_clr = 1'b1; tst_clk = 1'b1; end
    settle(); tst_clr = 1'b0; settle(); tst_clk = 1'b0; settle();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    check(tst_dout, 8'h00, "R5 clear wins over edge");
    read_chk(5, "R5 reg5 cleared");
    read_chk(0, "R5 reg0 not written");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule